// File: doc/BRIEF.md
# Trusted Code Execution Monitor

This block sits next to a small microcontroller core and watches, every clock, a handful of its signals: the program counter, the data-read and data-write strobes with their address, the interrupt line, and the DMA request with its address. It owns one output, a system reset request. This output goes high whenever the core breaks one of the protection rules.

The rules tie a secret key region to one fixed trusted code region. The key may be read only while the program counter lies in the trusted region. Control must enter that region at its first address and leave it from its last address. No interrupt or DMA activity may occur while trusted code runs. When the program counter reaches a chosen entry point, the reset-proof flag arms. From then on the normally legal exit becomes a violation, so a system reset is the only way out. All bounds are parameters and every range check includes both ends. Once raised, the reset request stays high until the monitor's own reset input is applied.

Top module: `trust_monitor`

## Requirements
- R1: With `rst_n` released and no rule broken, `sys_rst` stays low.
- R2: `rd_en` high with `daddr` in [KEY_LO, KEY_HI] while `pc` is outside [TCB_LO, TCB_HI] sets `sys_rst` high after the next rising clock edge.
- R3: A key-region read while `pc` is inside [TCB_LO, TCB_HI] raises no reset. A read of any address outside the key region raises no reset, whatever the value of `pc`.
- R4: `wr_en` high with `daddr` in the key region sets `sys_rst` after the next edge, whatever the value of `pc`.
- R5: When `pc` moves from inside the trusted region to outside it, a reset follows unless the previous `pc` was TCB_HI.
- R6: When `pc` moves from outside the trusted region to inside it, a reset follows unless the new `pc` is TCB_LO.
- R7: `pc` equal to POR_ENTRY arms a flag. Once the flag is armed, `pc` equal to TCB_HI sets `sys_rst`.
- R8: `irq` or `dma_en` high while `pc` is inside the trusted region sets `sys_rst` after the next edge.
- R9: `dma_en` high with `dma_addr` in the key region sets `sys_rst` after the next edge.
- R10: `sys_rst` stays high until `rst_n` is asserted. `rst_n` clears the armed flag and the region-tracking state, so the previous `pc` counts as outside the trusted region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low monitor reset |
| pc | input | AW | Program counter of the executing instruction |
| rd_en | input | 1 | Data read strobe |
| wr_en | input | 1 | Data write strobe |
| daddr | input | AW | Data access address |
| irq | input | 1 | Interrupt taken |
| dma_en | input | 1 | DMA transfer active |
| dma_addr | input | AW | DMA transfer address |
| sys_rst | output | 1 | Registered, sticky system reset request |

## Verification
The hardest state to reach is the armed reset-proof flag meeting the last trusted address. To get there, `pc` must first enter the region legally at TCB_LO, then step to POR_ENTRY while staying inside, and only then reach TCB_HI, all without tripping the entry, exit or event rules. The bench drives that walk, then sweeps every exit point and every entry point of a small 8-bit configuration, resetting between trials. It also checks that after a reset the same path to TCB_HI exits cleanly, because the flag was cleared.

// File: rtl/tm_pkg.sv
package tm_pkg;

  typedef logic [31:0] tm_addr_t;

  // inclusive window test on zero-extended addresses
  function automatic logic in_span(tm_addr_t a, tm_addr_t lo, tm_addr_t hi);
    return (a >= lo) && (a <= hi);
  endfunction

  typedef struct packed {
    logic key_read;
    logic key_write;
    logic dma_key;
    logic trusted_event;
    logic bad_entry;
    logic bad_exit;
    logic armed_exit;
  } tm_cause_t;

endpackage

// File: rtl/tm_flow_track.sv
module tm_flow_track import tm_pkg::*; #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] TCB_LO = '0,
  parameter logic [AW-1:0] TCB_HI = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc,
  output logic          pc_in,
  output logic          bad_entry,
  output logic          bad_exit
);

  logic          was_in_q;
  logic [AW-1:0] prev_pc_q;

  assign pc_in = in_span(tm_addr_t'(pc), tm_addr_t'(TCB_LO), tm_addr_t'(TCB_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_in_q  <= 1'b0;
      prev_pc_q <= '0;
    end else begin
      was_in_q  <= pc_in;
      prev_pc_q <= pc;
    end
  end

  assign bad_entry = !was_in_q && pc_in && (pc != TCB_LO);
  assign bad_exit  = was_in_q && !pc_in && (prev_pc_q != TCB_HI);

  // tracking register mirrors the window test one cycle late
  assert_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_in |=> was_in_q);

endmodule

// File: rtl/tm_por_latch.sv
module tm_por_latch #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] TCB_HI = '1,
  parameter logic [AW-1:0] POR_ENTRY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc,
  output logic          armed_q,
  output logic          armed_exit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              armed_q <= 1'b0;
    else if (pc == POR_ENTRY) armed_q <= 1'b1;
  end

  assign armed_exit = armed_q && (pc == TCB_HI);

  assert_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc == POR_ENTRY) |=> armed_q);

  assert_arm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

endmodule

// File: rtl/tm_bus_guard.sv
module tm_bus_guard import tm_pkg::*; #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] KEY_LO = '0,
  parameter logic [AW-1:0] KEY_HI = '1
) (
  input  logic          pc_in,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] daddr,
  input  logic          irq,
  input  logic          dma_en,
  input  logic [AW-1:0] dma_addr,
  output logic          key_read,
  output logic          key_write,
  output logic          dma_key,
  output logic          trusted_event
);

  logic d_hit, dma_hit;

  assign d_hit   = in_span(tm_addr_t'(daddr), tm_addr_t'(KEY_LO), tm_addr_t'(KEY_HI));
  assign dma_hit = in_span(tm_addr_t'(dma_addr), tm_addr_t'(KEY_LO), tm_addr_t'(KEY_HI));

  assign key_read      = rd_en && d_hit && !pc_in;
  assign key_write     = wr_en && d_hit;
  assign dma_key       = dma_en && dma_hit;
  assign trusted_event = pc_in && (irq || dma_en);

endmodule

// File: rtl/trust_monitor.sv
module trust_monitor import tm_pkg::*; #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] TCB_LO    = 16'hA000,
  parameter logic [AW-1:0] TCB_HI    = 16'hA0FF,
  parameter logic [AW-1:0] KEY_LO    = 16'h6A00,
  parameter logic [AW-1:0] KEY_HI    = 16'h6A3F,
  parameter logic [AW-1:0] POR_ENTRY = 16'hA080
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] daddr,
  input  logic          irq,
  input  logic          dma_en,
  input  logic [AW-1:0] dma_addr,
  output logic          sys_rst
);

  tm_cause_t cause;
  logic      pc_in, armed_q, violation, fault_q;
  logic      key_in_d, key_in_dma;

  tm_flow_track #(.AW(AW), .TCB_LO(TCB_LO), .TCB_HI(TCB_HI)) u_flow (
    .clk(clk), .rst_n(rst_n), .pc(pc), .pc_in(pc_in),
    .bad_entry(cause.bad_entry), .bad_exit(cause.bad_exit));

  tm_por_latch #(.AW(AW), .TCB_HI(TCB_HI), .POR_ENTRY(POR_ENTRY)) u_por (
    .clk(clk), .rst_n(rst_n), .pc(pc), .armed_q(armed_q),
    .armed_exit(cause.armed_exit));

  tm_bus_guard #(.AW(AW), .KEY_LO(KEY_LO), .KEY_HI(KEY_HI)) u_guard (
    .pc_in(pc_in), .rd_en(rd_en), .wr_en(wr_en), .daddr(daddr),
    .irq(irq), .dma_en(dma_en), .dma_addr(dma_addr),
    .key_read(cause.key_read), .key_write(cause.key_write),
    .dma_key(cause.dma_key), .trusted_event(cause.trusted_event));

  assign violation = |cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_q | violation;
  end

  assign sys_rst = fault_q;

  // port-level views used only by the properties below
  assign key_in_d   = in_span(tm_addr_t'(daddr), tm_addr_t'(KEY_LO), tm_addr_t'(KEY_HI));
  assign key_in_dma = in_span(tm_addr_t'(dma_addr), tm_addr_t'(KEY_LO), tm_addr_t'(KEY_HI));

  assert_key_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && key_in_d && !pc_in) |=> sys_rst);

  assert_key_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key_in_d) |=> sys_rst);

  assert_armed_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && pc == TCB_HI) |=> sys_rst);

  assert_trusted_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_in && (irq || dma_en)) |=> sys_rst);

  assert_dma_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && key_in_dma) |=> sys_rst);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> sys_rst);

endmodule

// File: tb/trust_monitor_bench.sv
module trust_monitor_bench;

  localparam logic [7:0] T_LO = 8'h40, T_HI = 8'h4F;
  localparam logic [7:0] K_LO = 8'h80, K_HI = 8'h87;
  localparam logic [7:0] P_EN = 8'h48, OUTSIDE = 8'h10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pc = OUTSIDE, daddr = '0, dma_addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0, irq = 1'b0, dma_en = 1'b0;
  logic       sys_rst;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  trust_monitor #(.AW(8), .TCB_LO(T_LO), .TCB_HI(T_HI), .KEY_LO(K_LO),
                  .KEY_HI(K_HI), .POR_ENTRY(P_EN)) u_trust_monitor (
    .clk(clk), .rst_n(rst_n), .pc(pc), .rd_en(rd_en), .wr_en(wr_en),
    .daddr(daddr), .irq(irq), .dma_en(dma_en), .dma_addr(dma_addr),
    .sys_rst(sys_rst));

  function automatic bit in_key(logic [7:0] a);
    return a >= K_LO && a <= K_HI;
  endfunction

  task automatic check(string req, logic exp);
    n_cmp++;
    if (sys_rst !== exp) begin
      n_bad++;
      $display("FAIL %s: sys_rst=%b expected=%b at %0t", req, sys_rst, exp, $time);
    end
  endtask

  // drive one cycle of inputs, then look just after the edge that registers it
  task automatic step(logic [7:0] p, logic r = 0, logic w = 0, logic [7:0] a = 0,
                      logic i = 0, logic d = 0, logic [7:0] da = 0);
    @(negedge clk);
    pc = p; rd_en = r; wr_en = w; daddr = a; irq = i; dma_en = d; dma_addr = da;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pc = OUTSIDE; rd_en = 0; wr_en = 0; irq = 0; dma_en = 0;
    daddr = '0; dma_addr = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    step(OUTSIDE);
    check("R1", 1'b0);
    step(8'h20, 1, 0, 8'h30);
    check("R1", 1'b0);

    // R2 / R3: read sweep from outside
    for (int a = 0; a < 256; a++) begin
      step(OUTSIDE, 1, 0, 8'(a));
      check(in_key(8'(a)) ? "R2" : "R3", in_key(8'(a)));
      if (sys_rst) do_reset();
    end

    // R3: key reads from inside trusted code
    do_reset();
    step(T_LO);
    for (int a = K_LO; a <= K_HI; a++) begin
      step(8'h41, 1, 0, 8'(a));
      check("R3", 1'b0);
    end

    // R4: key write from inside and outside
    do_reset(); step(T_LO); step(8'h42, 0, 1, K_HI); check("R4", 1'b1);
    do_reset(); step(OUTSIDE, 0, 1, K_LO); check("R4", 1'b1);
    do_reset(); step(OUTSIDE, 0, 1, 8'h7F); check("R4", 1'b0);

    // R5: exit sweep
    for (int a = T_LO; a <= T_HI; a++) begin
      do_reset();
      step(T_LO); step(8'(a));
      check("R5", 1'b0);
      step(8'h50);
      check("R5", (a == T_HI || a == P_EN) ? (a == P_EN) : 1'b1);
    end

    // R6: entry sweep
    for (int a = T_LO; a <= T_HI; a++) begin
      do_reset();
      step(OUTSIDE); step(8'(a));
      check("R6", a != T_LO);
    end

    // R7: armed walk; and same walk after reset without arming
    do_reset();
    step(T_LO); step(P_EN); check("R7", 1'b0);
    step(8'h4E); check("R7", 1'b0);
    step(T_HI); check("R7", 1'b1);
    do_reset();
    step(T_LO); step(8'h4E); step(T_HI); check("R7", 1'b0);
    step(8'h60); check("R10", 1'b0);

    // R8: events inside vs outside
    do_reset(); step(OUTSIDE, 0, 0, 0, 1); check("R8", 1'b0);
    step(OUTSIDE, 0, 0, 0, 0, 1, 8'h20); check("R8", 1'b0);
    step(T_LO); step(8'h44, 0, 0, 0, 1); check("R8", 1'b1);
    do_reset(); step(T_LO); step(8'h45, 0, 0, 0, 0, 1, 8'h20); check("R8", 1'b1);

    // R9: DMA into key region
    for (int a = 8'h7E; a <= 8'h89; a++) begin
      do_reset();
      step(OUTSIDE, 0, 0, 0, 0, 1, 8'(a));
      check("R9", in_key(8'(a)));
    end

    // R10: sticky until reset
    do_reset(); step(OUTSIDE, 1, 0, K_LO); check("R10", 1'b1);
    for (int k = 0; k < 5; k++) begin
      step(OUTSIDE);
      check("R10", 1'b1);
    end
    do_reset(); #1; check("R10", 1'b0);
    step(OUTSIDE); check("R10", 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule